// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block sits between a synchronous host and an external asynchronous static RAM of 512K bytes. The RAM has a 19-bit address, an 8-bit data bus and three active-low strobes: chip select, write enable and output enable. The host issues one word per request with `req`, `we`, `addr` and `wdata`. The controller then drives the strobes for as many clock cycles as the RAM's timing needs. A read returns `rdata` with a one-cycle `rvalid` pulse. A write finishes without any answer to the host. `ready` is high only while the controller can accept a new request.

Every strobe width and wait is set at elaboration. Each nanosecond limit is divided by the clock period and rounded up to a whole number of cycles.

A read holds chip select and output enable low. The data bus is captured on the last cycle of that window. A bus turnaround period follows, so that the RAM has released the data pins before the controller may drive them again.

A write holds chip select and write enable low together, with output enable kept high. Write data is driven only after the RAM's release time has passed since write enable fell. The controller stops driving the data on the same edge that ends the write.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset and whenever `ready` is high, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1 and `mem_dq_oe` is 0.
- R2: A read holds `mem_cs_n` and `mem_oe_n` at 0 and `mem_we_n` at 1, with `mem_addr` equal to the requested address, for RD cycles. RD is the largest of ceil(55 ns/T), ceil(25 ns/T) and ceil(55 ns/T), where T is the clock period. RD is 3 at 20 ns.
- R3: `rdata` holds the value of `mem_dq_i` sampled on the last cycle of the read window. `rvalid` is 1 for exactly one cycle, which is the first cycle after the strobes return high.
- R4: A write holds `mem_cs_n` and `mem_we_n` at 0 and `mem_oe_n` at 1 for WR cycles. WR is the largest of ceil(40/T), ceil(45/T), ceil(55/T) and HZ+DS. WR is 3 at 20 ns and 6 at 10 ns.
- R5: During a write, `mem_dq_oe` rises only after HZ = ceil(20 ns/T) cycles of write enable low. It then stays high until the edge on which `mem_we_n` rises, which gives at least DS = ceil(25 ns/T) cycles. `mem_dq_o` equals `wdata` throughout.
- R6: After a read, `ready` stays 0 for max(HZ,1) cycles after the strobes go high. No access starts during that turnaround and the bus is not driven.
- R7: `ready` falls on the cycle after a request is accepted. A `req` seen while `ready` is 0 is ignored and starts no access.
- R8: All cycle counts follow the clock-period parameter. With a 10 ns period a read window lasts 6 cycles, and a write drives data for 4 of its 6 write-enable-low cycles, starting after 2 of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request, taken when ready is high |
| we | input | 1 | 1 = write request, 0 = read request |
| addr | input | 19 | Word address of the request |
| wdata | input | 8 | Data to write |
| ready | output | 1 | Controller idle and able to accept a request |
| rvalid | output | 1 | One-cycle pulse, rdata holds read result |
| rdata | output | 8 | Captured read data |
| mem_addr | output | 19 | RAM address |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_dq_o | output | 8 | Data driven toward the RAM |
| mem_dq_oe | output | 1 | 1 = controller drives the data bus |
| mem_dq_i | input | 8 | Data bus as seen from the RAM side |

## Verification
Single writes followed by reads of the same address show whether the driven data lands in the bench's RAM model and whether it is captured back at the end of the read window. A write placed right after a read exercises the turnaround, and a read right after a write shows that no turnaround is added where none is needed. A read during which the host keeps `req` high with a different address separates real busy-time masking from an access that merely happens to look right. A second instance built with a 10 ns period tells correct per-parameter rounding apart from hard-coded counts.

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl #(
  parameter int AW             = 19,
  parameter int DW             = 8,
  parameter int CLK_PERIOD_NS  = 20,
  parameter int T_RD_CYCLE_NS  = 55,
  parameter int T_ACCESS_NS    = 55,
  parameter int T_OE_ACCESS_NS = 25,
  parameter int T_WE_PULSE_NS  = 40,
  parameter int T_CS_WR_NS     = 45,
  parameter int T_ADDR_WR_NS   = 45,
  parameter int T_DSETUP_NS    = 25,
  parameter int T_HIZ_NS       = 20,
  parameter int T_WR_CYCLE_NS  = 55
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          ready,
  output logic          rvalid,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_i
);

  function automatic int cyc(input int ns);
    return (ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int HZ_CYC   = cyc(T_HIZ_NS);
  localparam int DS_CYC   = cyc(T_DSETUP_NS);
  localparam int RD_CYC   = imax(1, imax(cyc(T_RD_CYCLE_NS), imax(cyc(T_ACCESS_NS), cyc(T_OE_ACCESS_NS))));
  localparam int WR_CYC   = imax(1, imax(imax(cyc(T_WE_PULSE_NS), cyc(T_CS_WR_NS)),
                                 imax(imax(cyc(T_ADDR_WR_NS), cyc(T_WR_CYCLE_NS)), HZ_CYC + DS_CYC)));
  localparam int TURN_CYC = imax(1, HZ_CYC);
  localparam int MAXC     = imax(RD_CYC, imax(WR_CYC, TURN_CYC));
  localparam int CNT_W    = (MAXC < 2) ? 1 : $clog2(MAXC + 1);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_TURN} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;

  assign ready = (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      mem_addr  <= '0;
      mem_cs_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_o  <= '0;
      mem_dq_oe <= 1'b0;
      rdata     <= '0;
      rvalid    <= 1'b0;
    end else begin
      rvalid <= 1'b0;
      case (st)
        S_IDLE: if (req) begin
          mem_addr <= addr;
          mem_cs_n <= 1'b0;
          if (we) begin
            mem_we_n  <= 1'b0;
            mem_dq_o  <= wdata;
            mem_dq_oe <= (HZ_CYC == 0);
            cnt       <= CNT_W'(WR_CYC - 1);
            st        <= S_WR;
          end else begin
            mem_oe_n <= 1'b0;
            cnt      <= CNT_W'(RD_CYC - 1);
            st       <= S_RD;
          end
        end
        S_RD: if (cnt == '0) begin
          rdata    <= mem_dq_i;
          rvalid   <= 1'b1;
          mem_cs_n <= 1'b1;
          mem_oe_n <= 1'b1;
          cnt      <= CNT_W'(TURN_CYC - 1);
          st       <= S_TURN;
        end else begin
          cnt <= cnt - 1'b1;
        end
        S_WR: if (cnt == '0) begin
          mem_cs_n  <= 1'b1;
          mem_we_n  <= 1'b1;
          mem_dq_oe <= 1'b0;
          st        <= S_IDLE;
        end else begin
          cnt <= cnt - 1'b1;
          if (cnt == CNT_W'(WR_CYC - HZ_CYC)) mem_dq_oe <= 1'b1;
        end
        S_TURN: if (cnt == '0) st <= S_IDLE;
                else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [7:0] we_lo, dq_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_lo  <= '0;
      dq_run <= '0;
    end else begin
      we_lo  <= mem_we_n  ? 8'd0 : ((we_lo  == 8'hFF) ? we_lo  : we_lo  + 8'd1);
      dq_run <= !mem_dq_oe ? 8'd0 : ((dq_run == 8'hFF) ? dq_run : dq_run + 8'd1);
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe));

  p_read_strobes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_cs_n && !mem_dq_oe));

  p_rvalid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);

  p_rvalid_after_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> ($past(!mem_oe_n) && mem_oe_n));

  p_write_strobes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_oe_n));

  p_we_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (int'(we_lo) >= WR_CYC));

  p_drive_in_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !mem_we_n);

  p_drive_after_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (int'(we_lo) >= HZ_CYC));

  p_data_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (int'(dq_run) >= DS_CYC));

  p_turnaround_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> !ready);

  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ready) |=> !ready);

endmodule

// File: tb/sram_async_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [18:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        ready, rvalid, cs_n, we_n, oe_n, dq_oe;
  logic [7:0]  rdata, dq_o, dq_i;
  logic [18:0] mem_addr;

  logic        f_req = 1'b0, f_we = 1'b0;
  logic [18:0] f_addr = '0;
  logic [7:0]  f_wdata = '0;
  logic        f_ready, f_rvalid, f_cs_n, f_we_n, f_oe_n, f_dq_oe;
  logic [7:0]  f_rdata, f_dq_o, f_dq_i;
  logic [18:0] f_mem_addr;

  int n_chk = 0;
  int n_fail = 0;

  sram_async_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .ready(ready), .rvalid(rvalid), .rdata(rdata), .mem_addr(mem_addr),
    .mem_cs_n(cs_n), .mem_we_n(we_n), .mem_oe_n(oe_n), .mem_dq_o(dq_o),
    .mem_dq_oe(dq_oe), .mem_dq_i(dq_i));

  sram_async_ctrl #(.CLK_PERIOD_NS(10)) dut_f (
    .clk(clk), .rst_n(rst_n), .req(f_req), .we(f_we), .addr(f_addr), .wdata(f_wdata),
    .ready(f_ready), .rvalid(f_rvalid), .rdata(f_rdata), .mem_addr(f_mem_addr),
    .mem_cs_n(f_cs_n), .mem_we_n(f_we_n), .mem_oe_n(f_oe_n), .mem_dq_o(f_dq_o),
    .mem_dq_oe(f_dq_oe), .mem_dq_i(f_dq_i));

  logic [7:0] store [16];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) store[i] <= 8'h00;
    end else if (!cs_n && !we_n && dq_oe) begin
      store[mem_addr[3:0]] <= dq_o;
    end
  end
  assign dq_i   = (!cs_n && !oe_n) ? store[mem_addr[3:0]] : 8'h00;
  assign f_dq_i = (!f_cs_n && !f_oe_n) ? 8'hC3 : 8'h00;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1, "R1 ready after reset", int'(ready), 1);
    chk({cs_n, we_n, oe_n} == 3'b111, "R1 strobes idle", int'({cs_n, we_n, oe_n}), 7);
    chk(dq_oe == 1'b0, "R1 bus released", int'(dq_oe), 0);
    chk(rvalid == 1'b0, "R1 no rvalid", int'(rvalid), 0);
  endtask

  task automatic t_write(input logic [18:0] a, input logic [7:0] d);
    int nwe = 1;
    int ndq = 0;
    bit bad_d = 0;
    bit bad_oe = 0;
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; wdata = ~d;
    chk(cs_n == 1'b0 && we_n == 1'b0, "R4 write strobes low", int'({cs_n, we_n}), 0);
    chk(oe_n == 1'b1, "R4 oe high in write", int'(oe_n), 1);
    chk(mem_addr == a, "R4 write address", int'(mem_addr), int'(a));
    chk(dq_oe == 1'b0, "R5 no drive in first cycle", int'(dq_oe), 0);
    chk(ready == 1'b0, "R7 busy after accept", int'(ready), 0);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (we_n) break;
      nwe++;
      if (dq_oe) ndq++;
      if (dq_oe && dq_o != d) bad_d = 1;
      if (!oe_n || cs_n) bad_oe = 1;
    end
    chk(nwe == 3, "R4 we low cycles", nwe, 3);
    chk(!bad_oe, "R4 strobes steady in write", int'(bad_oe), 0);
    chk(ndq == 2, "R5 drive cycles", ndq, 2);
    chk(!bad_d, "R5 driven data", int'(bad_d), 0);
    chk(dq_oe == 1'b0, "R5 release with we rise", int'(dq_oe), 0);
    chk(ready == 1'b1 && cs_n == 1'b1, "R7 ready after write", int'({ready, cs_n}), 3);
  endtask

  task automatic t_read(input logic [18:0] a, input logic [7:0] exp, input bit busy_req);
    int n = 1;
    bit bad_a = 0;
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    if (busy_req) addr = a ^ 19'h00055;
    else req = 1'b0;
    chk(cs_n == 1'b0 && oe_n == 1'b0 && we_n == 1'b1, "R2 read strobes",
        int'({cs_n, oe_n, we_n}), 1);
    chk(mem_addr == a, "R2 read address", int'(mem_addr), int'(a));
    chk(ready == 1'b0, "R7 busy during read", int'(ready), 0);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (oe_n) break;
      n++;
      if (mem_addr != a || cs_n) bad_a = 1;
    end
    chk(n == 3, "R2 read window cycles", n, 3);
    chk(!bad_a, "R2 address held", int'(bad_a), 0);
    chk(rvalid == 1'b1, "R3 rvalid after window", int'(rvalid), 1);
    chk(rdata == exp, "R3 read data", int'(rdata), int'(exp));
    chk(ready == 1'b0 && dq_oe == 1'b0 && cs_n == 1'b1, "R6 turnaround",
        int'({ready, dq_oe, cs_n}), 1);
    @(negedge clk);
    chk(rvalid == 1'b0, "R3 rvalid one cycle", int'(rvalid), 0);
    chk(ready == 1'b1, "R6 ready after turnaround", int'(ready), 1);
    if (busy_req) begin
      req = 1'b0;
      @(negedge clk);
      chk(cs_n == 1'b1 && oe_n == 1'b1 && we_n == 1'b1, "R7 busy req ignored",
          int'({cs_n, oe_n, we_n}), 7);
      chk(ready == 1'b1, "R7 still idle", int'(ready), 1);
    end
  endtask

  task automatic t_fast();
    int nwe = 1;
    int ndq = 0;
    int first = 0;
    int n = 1;
    f_req = 1'b1; f_we = 1'b1; f_addr = 19'h7FFFF; f_wdata = 8'h3C;
    @(negedge clk);
    f_req = 1'b0;
    chk(f_dq_oe == 1'b0, "R8 no early drive", int'(f_dq_oe), 0);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (f_we_n) break;
      nwe++;
      if (f_dq_oe) begin
        ndq++;
        if (first == 0) first = nwe;
      end
    end
    chk(nwe == 6, "R8 we low cycles", nwe, 6);
    chk(ndq == 4, "R8 drive cycles", ndq, 4);
    chk(first == 3, "R8 drive starts after 2 cycles", first, 3);
    f_req = 1'b1; f_we = 1'b0; f_addr = 19'h00001;
    @(negedge clk);
    f_req = 1'b0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (f_oe_n) break;
      n++;
    end
    chk(n == 6, "R8 read window cycles", n, 6);
    chk(f_rvalid == 1'b1 && f_rdata == 8'hC3, "R8 read data", int'(f_rdata), 8'hC3);
    repeat (3) @(negedge clk);
    chk(f_ready == 1'b1, "R8 idle again", int'(f_ready), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_write(19'h00003, 8'hA5);
    t_read(19'h00003, 8'hA5, 1'b0);
    t_write(19'h40007, 8'h5A);
    t_write(19'h00004, 8'hFF);
    t_read(19'h40007, 8'h5A, 1'b1);
    t_read(19'h00004, 8'hFF, 1'b0);
    t_read(19'h00009, 8'h00, 1'b0);
    t_fast();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule